// File: doc/BRIEF.md
# Non-volatile memory checksum sequencer

This block walks a word-addressed non-volatile memory through a simple request/acknowledge port and keeps a 16-bit running sum of the words it reads. The sum wraps on overflow. It has two operations, and the mode input picks one when start is accepted.

A check operation reads every word from index 0 up to and including the checksum slot. It reports a pass when the wrapped total equals a fixed target value. A refresh operation reads the words below the checksum slot and computes the target minus their sum. It then writes that value into the checksum slot, so a check run after a successful refresh always passes.

Only one operation runs at a time. If the port flags an error on any acknowledge, the operation stops at once and completes with an error indication.

Top module: `nvm_csum_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `fail_err` and `mem_req` are all low.
- R2: A check operation (`op_refresh`=0) issues reads (`mem_wr`=0) to indices 0, 1, …, CSUM_IDX in ascending order, one request per word and no other request.
- R3: Words are summed into a 16-bit accumulator that wraps. A check operation completes with `pass`=1 exactly when the total equals TARGET; otherwise it completes with `pass`=0 and `fail_err`=0.
- R4: A refresh operation (`op_refresh`=1) reads indices 0 … CSUM_IDX-1 in ascending order. It then issues one write (`mem_wr`=1) to index CSUM_IDX with data (TARGET − sum) mod 2^16. A write acknowledged without error completes with `pass`=1.
- R5: An acknowledge with `mem_err`=1, on a read or a write, ends the operation. No further request is issued. `done` is raised with `fail_err`=1 and `pass`=0.
- R6: `done` is a single-cycle pulse in the cycle after the final acknowledge. `busy` is high from the cycle after start is accepted until that pulse, and it is low while `done` is high.
- R7: A start pulse while `busy` is high is ignored. The running operation keeps its mode, sequence and result.
- R8: The accumulator and index are cleared when each operation is accepted. This includes a start accepted in the same cycle as the previous operation's `done`.
- R9: While `mem_req` is high and not yet acknowledged, `mem_req`, `mem_wr`, `mem_addr` and `mem_wdata` hold their values.
- R10: A check operation run after a successful refresh of the same memory completes with `pass`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when not busy |
| op_refresh | input | 1 | 0 = check, 1 = refresh checksum slot |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last operation, valid from `done` |
| fail_err | output | 1 | Last operation ended on a port error |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_wr | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word index of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request acknowledged this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Request failed, valid with `mem_ack` |

## Verification
Two pairs of events can coincide. In the first, the last word's acknowledge can carry an error, so completion and error arrive in the same cycle. The bench injects errors on the final read of a check and on the write of a refresh, and expects `fail_err`=1 with `pass`=0 and no later request. In the second, a new start can arrive in the very cycle the previous `done` pulses. The bench raises start at that sampling point and expects the follow-on check to run a full, freshly cleared sequence and pass.

// File: rtl/nvm_csum_pkg.sv
`timescale 1ns/1ps
// Shared types for the checksum sequencer.
package nvm_csum_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/nvm_csum_acc.sv
`timescale 1ns/1ps
// Wrapping sum register.
// Holds the running modulo-2^DATA_W sum of the words read so far.
// Assumes clr and add_en are never raised together by the controller.
module nvm_csum_acc #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [DATA_W-1:0] addend,
    output logic [DATA_W-1:0] sum_q,
    output logic [DATA_W-1:0] sum_nx
);
    // Next sum if the current addend is taken; the carry is dropped.
    assign sum_nx = sum_q + addend;

    // Register update: clear at operation start, accumulate on each read.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (clr)    sum_q <= '0;
        else if (add_en) sum_q <= sum_nx;
    end

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0));
endmodule

// File: rtl/nvm_csum_idx.sv
`timescale 1ns/1ps
// Word index counter.
// Steps through word indices and flags when the current index equals limit.
// Assumes limit is held stable during an operation.
module nvm_csum_idx #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    input  logic [ADDR_W-1:0] limit,
    output logic [ADDR_W-1:0] idx,
    output logic              at_limit
);
    // Comparison against the last index of the current read pass.
    assign at_limit = (idx == limit);

    // Index register: cleared on operation start, advanced per accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx + 1'b1;
    end

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/nvm_csum_ctrl.sv
`timescale 1ns/1ps
// Operation sequencer.
// Accepts start when idle, runs the read pass and the optional write of the
// checksum slot, and produces done/pass/fail_err.
// Assumes the port returns exactly one mem_ack per request.
module nvm_csum_ctrl
    import nvm_csum_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int unsigned CSUM_IDX = 63,
    parameter logic [DATA_W-1:0] TARGET = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_refresh,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic              last_word,
    input  logic [DATA_W-1:0] sum_nx,
    output logic              acc_clr,
    output logic              acc_add,
    output logic              idx_clr,
    output logic              idx_inc,
    output logic              mode_q,
    output logic              in_read,
    output logic              in_write,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail_err
);
    // With the checksum slot at index 0, a refresh has nothing to read.
    localparam bit NO_READ_REFRESH = (CSUM_IDX == 0);

    seq_state_t state_q;
    logic       accept;

    assign accept   = start && (state_q == SEQ_IDLE);
    assign in_read  = (state_q == SEQ_READ);
    assign in_write = (state_q == SEQ_WRITE);
    assign busy     = (state_q != SEQ_IDLE);

    // Datapath strobes for the accumulator and the index counter.
    always_comb begin
        acc_clr = accept;
        idx_clr = accept;
        acc_add = in_read && mem_ack && !mem_err;
        idx_inc = in_read && mem_ack && !mem_err && !last_word;
    end

    // State, mode latch and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            mode_q   <= 1'b0;
            done     <= 1'b0;
            pass     <= 1'b0;
            fail_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        mode_q   <= op_refresh;
                        pass     <= 1'b0;
                        fail_err <= 1'b0;
                        state_q  <= (op_refresh && NO_READ_REFRESH) ? SEQ_WRITE : SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            state_q  <= SEQ_IDLE;
                            done     <= 1'b1;
                            fail_err <= 1'b1;
                            pass     <= 1'b0;
                        end else if (last_word) begin
                            if (mode_q) begin
                                state_q <= SEQ_WRITE;
                            end else begin
                                state_q <= SEQ_IDLE;
                                done    <= 1'b1;
                                pass    <= (sum_nx == TARGET);
                            end
                        end
                    end
                end
                SEQ_WRITE: begin
                    if (mem_ack) begin
                        state_q  <= SEQ_IDLE;
                        done     <= 1'b1;
                        fail_err <= mem_err;
                        pass     <= !mem_err;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (mode_q == $past(mode_q)));
    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_err |-> !pass);
endmodule

// File: rtl/nvm_csum_seq.sv
`timescale 1ns/1ps
// Checksum sequencer top.
// Validates or refreshes the checksum slot of a word memory through a
// request/acknowledge port. Assumes mem_rdata and mem_err are valid with mem_ack.
module nvm_csum_seq #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 16,
    parameter int unsigned CSUM_IDX = 63,
    parameter logic [DATA_W-1:0] TARGET = 16'hBABA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_refresh,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail_err,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err
);
    localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(CSUM_IDX);
    localparam logic [ADDR_W-1:0] LAST_REFRESH_A =
        (CSUM_IDX == 0) ? '0 : ADDR_W'(CSUM_IDX - 1);

    logic              acc_clr, acc_add, idx_clr, idx_inc;
    logic              mode_q, in_read, in_write, last_word;
    logic [ADDR_W-1:0] idx, limit;
    logic [DATA_W-1:0] sum_q, sum_nx;

    // The read pass ends one word earlier for a refresh.
    assign limit = mode_q ? LAST_REFRESH_A : SLOT_A;

    nvm_csum_acc #(.DATA_W(DATA_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add_en(acc_add),
        .addend(mem_rdata), .sum_q(sum_q), .sum_nx(sum_nx)
    );

    nvm_csum_idx #(.ADDR_W(ADDR_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc),
        .limit(limit), .idx(idx), .at_limit(last_word)
    );

    nvm_csum_ctrl #(.DATA_W(DATA_W), .CSUM_IDX(CSUM_IDX), .TARGET(TARGET)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_refresh(op_refresh),
        .mem_ack(mem_ack), .mem_err(mem_err), .last_word(last_word),
        .sum_nx(sum_nx), .acc_clr(acc_clr), .acc_add(acc_add),
        .idx_clr(idx_clr), .idx_inc(idx_inc), .mode_q(mode_q),
        .in_read(in_read), .in_write(in_write), .busy(busy), .done(done),
        .pass(pass), .fail_err(fail_err)
    );

    // Port drive: the address is the counter during reads and the slot during the write.
    always_comb begin
        mem_req   = in_read || in_write;
        mem_wr    = in_write;
        mem_addr  = in_write ? SLOT_A : idx;
        mem_wdata = TARGET - sum_q;
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_wr) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));
    // R4
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wr) |-> (mem_addr == SLOT_A));
    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr <= SLOT_A));
    // R5
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (!mem_req && done && fail_err));
endmodule

// File: tb/test_nvm_csum_seq.sv
`timescale 1ns/1ps
module test_nvm_csum_seq;
    localparam int NW = 64;
    localparam logic [15:0] TGT = 16'hBABA;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_refresh = 1'b0;
    logic busy, done, pass, fail_err, mem_req, mem_wr;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic mem_ack = 1'b0, mem_err = 1'b0;
    logic [15:0] mem_rdata = '0;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] mem [0:NW-1];
    int lg_n = 0;
    int lg_addr [0:127];
    bit lg_we [0:127];
    logic [15:0] lg_wd [0:127];
    int lat = 0, waitc = 0, err_addr = -1;
    bit err_we = 0, pend = 0, stab_bad = 0;
    logic [7:0] p_addr;
    logic p_we;
    logic [15:0] p_wd;
    bit r_pass, r_err;

    nvm_csum_seq i_nvm_csum_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_refresh(op_refresh),
        .busy(busy), .done(done), .pass(pass), .fail_err(fail_err),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: acknowledges after lat idle cycles, logs every request.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
                pend = 0;
            end else if (mem_req) begin
                if (pend && (mem_addr != p_addr || mem_wr != p_we ||
                             (mem_wr && mem_wdata != p_wd)))
                    stab_bad = 1;
                pend = 1; p_addr = mem_addr; p_we = mem_wr; p_wd = mem_wdata;
                if (waitc < lat) waitc++;
                else begin
                    waitc = 0;
                    if (lg_n < 128) begin
                        lg_addr[lg_n] = int'(mem_addr);
                        lg_we[lg_n] = mem_wr;
                        lg_wd[lg_n] = mem_wdata;
                    end
                    lg_n++;
                    mem_err = (int'(mem_addr) == err_addr) && (mem_wr == err_we);
                    if (mem_wr) begin
                        if (!mem_err) mem[mem_addr[5:0]] = mem_wdata;
                    end else mem_rdata = mem[mem_addr[5:0]];
                    mem_ack = 1'b1;
                end
            end
        end
    end

    function automatic logic [15:0] sum_to(input int n);
        logic [15:0] s = '0;
        for (int k = 0; k < n; k++) s = s + mem[k];
        return s;
    endfunction

    // Waits for done at negedges; with chain set, starts a check in the done cycle.
    task automatic wait_done(input bit chain);
        int n = 0;
        forever begin
            @(negedge clk);
            if (done) begin
                r_pass = pass; r_err = fail_err;
                chk(!busy, "R6 busy low with done", busy, 0);
                if (chain) begin
                    start = 1'b1; op_refresh = 1'b0; lg_n = 0; stab_bad = 0;
                end
                break;
            end
            n++;
            if (n > 3000) begin
                chk(0, "R6 watchdog", n, 0);
                break;
            end
        end
    endtask

    task automatic run_op(input bit upd, input bit poke, input bit chain);
        @(negedge clk);
        lg_n = 0; stab_bad = 0;
        start = 1'b1; op_refresh = upd;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R6 busy after start", busy, 1);
        if (poke) begin
            @(negedge clk); start = 1'b1; op_refresh = !upd;
            @(negedge clk); start = 1'b0;
        end
        wait_done(chain);
    endtask

    task automatic reads_ok(input int n, input string tag);
        bit ok = 1;
        for (int k = 0; k < n; k++) if (lg_addr[k] != k || lg_we[k]) ok = 0;
        chk(ok, tag, lg_n, n);
    endtask

    task automatic fill(input int p);
        for (int k = 0; k < NW; k++)
            case (p)
                0: mem[k] = 16'h0000;
                1: mem[k] = 16'hFFFF;
                2: mem[k] = 16'(k * 16'h1234 + 7);
                default: mem[k] = 16'((k * k * 16'h9E37) ^ k);
            endcase
    endtask

    initial begin
        logic [15:0] exp_s;
        fill(2);
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !pass && !fail_err && !mem_req, "R1 reset state",
            {busy, done, pass, fail_err, mem_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 idle after reset", {busy, done, mem_req}, 0);

        // Sweep of patterns and latencies: check, refresh, check.
        for (int p = 0; p < 4; p++) begin
            for (int l = 0; l < 3; l++) begin
                fill(p); lat = l;
                exp_s = sum_to(NW);
                run_op(0, 0, 0);
                reads_ok(NW, "R2 check read sequence");
                chk(lg_n == NW, "R2 check request count", lg_n, NW);
                chk(r_pass == (exp_s == TGT) && !r_err, "R3 check result", r_pass, exp_s == TGT);
                exp_s = TGT - sum_to(NW - 1);
                run_op(1, 0, 0);
                reads_ok(NW - 1, "R4 refresh read sequence");
                chk(lg_n == NW && lg_we[NW-1] && lg_addr[NW-1] == NW - 1,
                    "R4 refresh write slot", lg_addr[NW-1], NW - 1);
                chk(lg_wd[NW-1] == exp_s, "R4 refresh write data", lg_wd[NW-1], exp_s);
                chk(r_pass && !r_err, "R4 refresh pass", r_pass, 1);
                chk(!stab_bad, "R9 request held until ack", stab_bad, 0);
                run_op(0, 0, 0);
                chk(r_pass && !r_err, "R10 check after refresh", r_pass, 1);
            end
        end

        // R3 corrupted slot fails without error.
        lat = 0;
        mem[NW-1] = mem[NW-1] + 16'd1;
        run_op(0, 0, 0);
        chk(!r_pass && !r_err, "R3 mismatch fails", r_pass, 0);

        // R5 errors on reads (incl. final read, same cycle as completion) and on the write.
        lat = 1;
        for (int e = 0; e < 5; e++) begin
            int ea, exp_n;
            bit upd;
            case (e)
                0: begin ea = 0;  upd = 0; err_we = 0; end
                1: begin ea = 20; upd = 0; err_we = 0; end
                2: begin ea = 63; upd = 0; err_we = 0; end
                3: begin ea = 10; upd = 1; err_we = 0; end
                default: begin ea = 63; upd = 1; err_we = 1; end
            endcase
            err_addr = ea;
            exp_n = (upd && err_we) ? NW : ea + 1;
            run_op(upd, 0, 0);
            chk(r_err && !r_pass, "R5 error result", {r_err, r_pass}, 2);
            repeat (5) @(negedge clk);
            chk(lg_n == exp_n && !mem_req, "R5 no request after error", lg_n, exp_n);
        end
        err_addr = -1; err_we = 0;

        // R7 start while busy is ignored.
        lat = 0; fill(3);
        exp_s = sum_to(NW);
        run_op(0, 1, 0);
        reads_ok(NW, "R7 sequence unchanged by start while busy");
        chk(lg_n == NW && r_pass == (exp_s == TGT) && !r_err, "R7 result unchanged", lg_n, NW);

        // R8 start in the done cycle: refresh then chained check.
        fill(1);
        run_op(1, 0, 1);
        chk(r_pass, "R8 first op of chain", r_pass, 1);
        @(negedge clk); start = 1'b0;
        wait_done(0);
        reads_ok(NW, "R8 chained check full sequence");
        chk(lg_n == NW && r_pass && !r_err, "R8 chained check passes", r_pass, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Global watchdog: counts as a failed check and still prints the summary.
    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule